// File: doc/BRIEF.md
# Multi-Master I2C Byte Controller

This block is the master side of an I2C bus that other masters may share. A host hands it one command at a time: begin a transfer, send a byte, receive a byte, or end the transfer. The controller turns each command into open-drain activity on the clock and data lines. It reports the acknowledge it saw after a sent byte, returns each received byte, and raises a flag when another master wins the bus.

Both lines are driven only by pull-low enables and observed through two-flop synchronizers. One parameter sets the bit timing as a count of system-clock cycles per quarter bit. For example, 250 cycles at 100 MHz gives 100 kHz, and 62 gives about 400 kHz. The controller watches the bus for START and STOP conditions made by other masters, so it knows when the bus is free. It waits while a target holds SCL low. If it loses arbitration, it clocks out the rest of the byte with SDA released and then leaves the bus without a STOP.

Top module: `i2c_mm_master`

## Requirements
- R1: After reset and whenever the controller is idle, scl_oe and sda_oe are 0. After reset, busy, arb_lost and bus_busy are 0.
- R2: cmd_op encoding is 0 = START, 1 = WRITE, 2 = READ, 3 = STOP. START is accepted only when the controller is idle and bus_busy is 0. A START issued while bus_busy is 1 is ignored: busy stays 0 and both enables stay 0. WRITE, READ and STOP are accepted only after a completed START.
- R3: A START makes SDA fall while SCL is high. After it, SCL is held low until the next command.
- R4: WRITE shifts cmd_data out most significant bit first. A ninth clock then samples the acknowledge: ack_ok becomes 1 when SDA is low and 0 when SDA is high.
- R5: READ releases SDA for eight clocks and places the sampled byte, first bit as the most significant, on rd_data. On the ninth clock it drives SDA low (ACK) when cmd_last is 0 and leaves it released (NACK) when cmd_last is 1.
- R6: STOP makes SDA rise while SCL is high, after which the controller is idle. bus_busy returns to 0 after a STOP from any master.
- R7: During data and acknowledge bits, SDA changes only while SCL is low. Every high phase of SCL lasts at least 2*QTR clock cycles.
- R8: When a target holds SCL low, the controller does not start timing the high phase until it sees SCL high. The high phase that follows still lasts at least 2*QTR cycles.
- R9: If SDA reads low during a high phase of a WRITE bit in which the controller released it, arbitration is lost. The controller then releases SDA for the remaining bits, still produces eight SCL high pulses for the byte, and releases both lines without a STOP. It sets arb_lost, which clears on the next accepted START.
- R10: bus_busy goes to 1 on any START condition seen on the lines and to 0 on any STOP condition, including those made by other masters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is 0 |
| cmd_op | input | 2 | Command code: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data | input | 8 | Byte to send on WRITE |
| cmd_last | input | 1 | On READ, answer with NACK instead of ACK |
| busy | output | 1 | A command is in progress |
| ack_ok | output | 1 | Last sent byte was acknowledged |
| rd_data | output | 8 | Last received byte |
| arb_lost | output | 1 | Arbitration was lost in the last transfer |
| bus_busy | output | 1 | A START has been seen without a following STOP |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest case to reach from the ports is arbitration loss in mid-byte, because it needs a second master on the wired-AND bus. The bench models that master. It holds SDA low during the first address bit, where the controller sends a 1. It then counts the SCL pulses that follow and checks that the controller goes quiet without a STOP. The same rival model makes START and STOP conditions of its own, which tests bus_busy tracking and START refusal. A target model that stretches SCL after the address acknowledge tests the wait behaviour.

// File: rtl/i2c_mm_master.sv
module i2c_mm_master #(
  parameter int QTR = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_last,
  output logic       busy,
  output logic       ack_ok,
  output logic [7:0] rd_data,
  output logic       arb_lost,
  output logic       bus_busy,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int HALF = 2 * QTR;
  localparam int CW = $clog2(HALF + 1);

  typedef enum logic [3:0] {S_IDLE, S_STA, S_STB, S_HOLD, S_LO, S_HI, S_SPA, S_SPB, S_SPC} st_t;
  st_t st;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1; bus_busy <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (scl_s && scl_q && sda_q && !sda_s) bus_busy <= 1'b1;
      else if (scl_s && scl_q && !sda_q && sda_s) bus_busy <= 1'b0;
    end

  logic [CW-1:0] cnt;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic rd, last, lost;
  wire cnt_end = cnt == CW'(HALF - 1);
  wire cnt_mid = cnt == CW'(QTR - 1);
  wire go_start = cmd_valid && st == S_IDLE && cmd_op == 2'd0 && !bus_busy;

  assign busy = !(st == S_IDLE || st == S_HOLD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0; cnt <= '0; bitn <= '0; sh <= '0;
      rd <= 1'b0; last <= 1'b0; lost <= 1'b0; arb_lost <= 1'b0; ack_ok <= 1'b0; rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (go_start) begin st <= S_STA; arb_lost <= 1'b0; lost <= 1'b0; end
        end
        S_STA:
          if (bus_busy) begin st <= S_IDLE; arb_lost <= 1'b1; end
          else if (scl_s && sda_s) begin
            cnt <= cnt + 1'b1;
            if (cnt_end) begin cnt <= '0; sda_oe <= 1'b1; st <= S_STB; end
          end else cnt <= '0;
        S_STB: begin
          cnt <= cnt + 1'b1;
          if (cnt_end) begin cnt <= '0; scl_oe <= 1'b1; st <= S_HOLD; end
        end
        S_HOLD:
          if (cmd_valid) begin
            bitn <= '0; cnt <= '0;
            case (cmd_op)
              2'd1: begin sh <= cmd_data; rd <= 1'b0; st <= S_LO; end
              2'd2: begin sh <= '0; rd <= 1'b1; last <= cmd_last; st <= S_LO; end
              2'd3: st <= S_SPA;
              default: ;
            endcase
          end
        S_LO: begin
          cnt <= cnt + 1'b1;
          if (cnt_mid) sda_oe <= (bitn == 4'd8) ? (rd && !last) : (!rd && !lost && !sh[7]);
          if (cnt_end) begin cnt <= '0; scl_oe <= 1'b0; st <= S_HI; end
        end
        S_HI:
          if (!scl_s) cnt <= '0;
          else begin
            cnt <= cnt + 1'b1;
            if (cnt_mid) begin
              if (bitn != 4'd8) begin
                sh <= {sh[6:0], sda_s};
                if (!rd && !sda_oe && !sda_s) lost <= 1'b1;
              end else if (!rd) ack_ok <= !sda_s;
            end
            if (cnt_end) begin
              cnt <= '0;
              if (bitn == 4'd7 && lost) begin
                st <= S_IDLE; arb_lost <= 1'b1; sda_oe <= 1'b0;
              end else begin
                scl_oe <= 1'b1;
                if (bitn == 4'd8) begin
                  st <= S_HOLD;
                  if (rd) rd_data <= sh;
                end else begin
                  bitn <= bitn + 1'b1; st <= S_LO;
                end
              end
            end
          end
        S_SPA: begin
          cnt <= cnt + 1'b1;
          if (cnt_mid) sda_oe <= 1'b1;
          if (cnt_end) begin cnt <= '0; scl_oe <= 1'b0; st <= S_SPB; end
        end
        S_SPB:
          if (!scl_s) cnt <= '0;
          else begin
            cnt <= cnt + 1'b1;
            if (cnt_end) begin cnt <= '0; sda_oe <= 1'b0; st <= S_SPC; end
          end
        S_SPC: begin
          cnt <= cnt + 1'b1;
          if (cnt_end) begin cnt <= '0; st <= S_IDLE; end
        end
        default: st <= S_IDLE;
      endcase
    end

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !scl_oe && !sda_oe);
  // R2
  start_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && st == S_IDLE && bus_busy) |=> st == S_IDLE);
  // R7
  sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && $past(st == S_HI)) |-> $stable(sda_oe));
  // R8
  stretch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && !scl_s) |=> !scl_oe);
  // R9
  lost_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> !sda_oe);
  // R9
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !scl_oe && !sda_oe);
endmodule

// File: tb/test_i2c_mm_master.sv
`timescale 1ns/1ps
module test_i2c_mm_master;
  localparam int QTR = 4;
  localparam int HALF = 2 * QTR;
  localparam int STRETCH = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_last = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic busy, ack_ok, arb_lost, bus_busy, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic tgt_sda_low = 1'b0, rival_force = 1'b0, rival_arb = 1'b0, stretch_en = 1'b0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  int stl = 0, bitcnt = 0, rises = 0, hi_run = 0, ri = 0;
  bit act = 0, skipf = 0, in_addr = 0, addr_slot = 0, matched = 0, rdm = 0, sending = 0;
  bit macked = 0, str_flag = 0, chk_str = 0, pscl = 1, psda = 1;
  logic [7:0] tsh = 8'h00, rbyte = 8'h00;
  int evq[$], wq[$], mack_q[$];
  int rq[$] = '{'h96, 'h5A};

  wire rival_low = rival_force || (rival_arb && act && bitcnt == 0);
  wire scl = !(scl_oe || stl > 0);
  wire sda = !(sda_oe || tgt_sda_low || rival_low);

  always #4 clk = !clk;

  i2c_mm_master #(.QTR(QTR)) i_i2c_mm_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_last(cmd_last), .busy(busy), .ack_ok(ack_ok), .rd_data(rd_data), .arb_lost(arb_lost),
    .bus_busy(bus_busy), .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe));

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, actv, expv);
    end
  endtask

  task automatic chkq(input string req, input int got[$], input int expq[$]);
    nchk++;
    if (got != expq) begin
      nerr++;
      $display("FAIL %s: actual %p expected %p", req, got, expq);
    end
  endtask

  // Reference model of target, rival master and line monitor, updated every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      act = 0; stl = 0; hi_run = 0;
    end else begin
      if (stl > 0) stl--;
      if (scl) hi_run++;
      if (pscl && scl && psda && !sda) begin
        evq.push_back(256); act = 1; skipf = 1; bitcnt = 0; rises = 0;
        in_addr = 1; matched = 0; rdm = 0; sending = 0; tgt_sda_low = 0;
      end else if (pscl && scl && !psda && sda) begin
        evq.push_back(257); act = 0; tgt_sda_low = 0; sending = 0;
      end else if (act && !pscl && scl) begin
        rises++;
        if (str_flag) begin chk_str = 1; str_flag = 0; end
        if (bitcnt < 8) tsh = {tsh[6:0], sda};
        else if (rdm && !addr_slot) begin macked = !sda; mack_q.push_back(!sda); end
      end else if (pscl && !scl) begin
        // R7: every high phase lasts at least HALF cycles
        chk(hi_run >= HALF, "R7 scl high width", hi_run, HALF);
        if (chk_str) begin
          // R8: full high phase after the stretch ends
          chk(hi_run >= HALF, "R8 high width after stretch", hi_run, HALF);
          chk_str = 0;
        end
        if (act) begin
          if (skipf) skipf = 0;
          else if (bitcnt == 7) begin
            bitcnt = 8;
            evq.push_back(int'(tsh));
            addr_slot = in_addr;
            if (in_addr) begin
              matched = tsh[7:1] == 7'h50; rdm = tsh[0]; in_addr = 0; tgt_sda_low = matched;
            end else if (!rdm) begin
              if (matched) wq.push_back(int'(tsh));
              tgt_sda_low = matched;
            end else tgt_sda_low = 0;
          end else if (bitcnt == 8) begin
            bitcnt = 0;
            sending = matched && rdm && (addr_slot || macked) && ri < rq.size();
            if (sending) begin rbyte = rq[ri][7:0]; ri++; end
            tgt_sda_low = sending && !rbyte[7];
            if (addr_slot && stretch_en) begin stl = STRETCH; str_flag = 1; end
          end else begin
            bitcnt++;
            tgt_sda_low = sending && !rbyte[7 - bitcnt];
          end
        end
      end
      if (pscl && !scl) hi_run = 0;
      if (!pscl && scl) hi_run = 1;
      pscl = scl; psda = sda;
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [7:0] d, input logic l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_last = l;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(!busy && !arb_lost && !bus_busy, "R1 flags low", {busy, arb_lost, bus_busy}, 0);

    // R3 R4 R6: write transfer with two data bytes
    evq.delete();
    cmd(2'd0, 8'h00, 1'b0);
    chk(scl_oe && sda_oe && bus_busy, "R3 start holds bus", {scl_oe, sda_oe, bus_busy}, 7);
    cmd(2'd1, 8'hA0, 1'b0);
    chk(ack_ok, "R4 address ack", ack_ok, 1);
    cmd(2'd1, 8'h3C, 1'b0);
    chk(ack_ok, "R4 data ack", ack_ok, 1);
    cmd(2'd1, 8'hC5, 1'b0);
    cmd(2'd3, 8'h00, 1'b0);
    repeat (4) @(negedge clk);
    chk(!bus_busy && !scl_oe && !sda_oe, "R6 idle after stop", {bus_busy, scl_oe, sda_oe}, 0);
    chkq("R4 written bytes", wq, '{'h3C, 'hC5});
    chkq("R3 R6 line events", evq, '{256, 'hA0, 'h3C, 'hC5, 257});

    // R4 NACK from absent target
    cmd(2'd0, 8'h00, 1'b0);
    cmd(2'd1, 8'h44, 1'b0);
    chk(!ack_ok, "R4 nack seen", ack_ok, 0);
    cmd(2'd3, 8'h00, 1'b0);

    // R5 read two bytes, ACK then NACK
    evq.delete(); mack_q.delete();
    cmd(2'd0, 8'h00, 1'b0);
    cmd(2'd1, 8'hA1, 1'b0);
    chk(ack_ok, "R5 read address ack", ack_ok, 1);
    cmd(2'd2, 8'h00, 1'b0);
    chk(rd_data == 8'h96, "R5 first read byte", rd_data, 'h96);
    cmd(2'd2, 8'h00, 1'b1);
    chk(rd_data == 8'h5A, "R5 last read byte", rd_data, 'h5A);
    cmd(2'd3, 8'h00, 1'b0);
    chkq("R5 master ack pattern", mack_q, '{1, 0});
    chkq("R5 line events", evq, '{256, 'hA1, 'h96, 'h5A, 257});

    // R8 clock stretching after address
    wq.delete(); stretch_en = 1'b1;
    cmd(2'd0, 8'h00, 1'b0);
    cmd(2'd1, 8'hA0, 1'b0);
    t0 = nchk;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_data = 8'h11; cmd_last = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      int dur = 1;
      while (busy) begin @(negedge clk); dur++; end
      chk(dur > STRETCH, "R8 byte waits for stretch", dur, STRETCH);
    end
    chk(ack_ok, "R8 ack after stretch", ack_ok, 1);
    cmd(2'd3, 8'h00, 1'b0);
    stretch_en = 1'b0;
    chkq("R8 byte after stretch", wq, '{'h11});
    chk(nchk > t0, "R8 stretch high checked", nchk, t0);

    // R9 arbitration loss on first address bit
    evq.delete(); rival_arb = 1'b1;
    cmd(2'd0, 8'h00, 1'b0);
    cmd(2'd1, 8'hA0, 1'b0);
    rival_arb = 1'b0;
    repeat (3) @(negedge clk);
    chk(arb_lost, "R9 arb_lost set", arb_lost, 1);
    chk(!scl_oe && !sda_oe, "R9 bus released", {scl_oe, sda_oe}, 0);
    chk(rises == 8, "R9 eight clocks", rises, 8);
    chk(bus_busy, "R10 bus still owned", bus_busy, 1);
    chkq("R9 no stop issued", evq, '{256});
    // rival ends the transfer itself
    rival_force = 1'b1; repeat (6) @(negedge clk);
    rival_force = 1'b0; repeat (6) @(negedge clk);
    chk(!bus_busy, "R10 rival stop frees bus", bus_busy, 0);

    // R2 R10 start refused while a rival holds the bus
    rival_force = 1'b1; repeat (6) @(negedge clk);
    chk(bus_busy, "R10 rival start seen", bus_busy, 1);
    cmd(2'd0, 8'h00, 1'b0);
    repeat (10) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R2 start ignored", {busy, scl_oe, sda_oe}, 0);
    chk(arb_lost, "R2 arb_lost kept", arb_lost, 1);
    rival_force = 1'b0; repeat (6) @(negedge clk);

    // R9 flag clears on next accepted start
    cmd(2'd0, 8'h00, 1'b0);
    chk(!arb_lost && scl_oe, "R9 cleared by start", {arb_lost, scl_oe}, 1);
    cmd(2'd1, 8'hA0, 1'b0);
    chk(ack_ok, "R4 ack after recovery", ack_ok, 1);
    cmd(2'd3, 8'h00, 1'b0);
    repeat (4) @(negedge clk);
    chk(!scl_oe && !sda_oe && !bus_busy, "R1 idle at end", {scl_oe, sda_oe, bus_busy}, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule